// File: doc/BRIEF.md
# Radix-16 Sequential Significand Multiplier

This block multiplies two normalised floating-point significands, each carrying its explicit leading one, by shift-and-add. Each clock retires four multiplier bits. The partial-product accumulator shifts right by one nibble per step, and the bits it drops are ORed into a sticky flag rather than stored. After the last step a single normalisation stage aligns the product. If the product is two or more, the working exponent goes up by one. If the product is below two, the significand moves up one place. The block returns the retained significand, the adjusted exponent, a guard bit and a sticky bit.

A floating-point multiply unit uses it between operand unpacking and rounding. The unit presents both significands together with the already combined, biased working exponent and pulses `start`. It then waits for `done`. Rounding, exception flags and special operands belong to the surrounding unit.

Top module: `radix16_sig_mul`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `done`, `sig_out`, `exp_out`, `guard` and `sticky` all become 0.
- R2: Let `start` be high at an edge where `busy` is low. Then `done` goes high for exactly one cycle, 15 edges later. With the default 53-bit width that is 14 nibble steps plus one normalisation edge.
- R3: A `start` pulse while `busy` is high is ignored. The running operation completes with its own operands and its normal latency.
- R4: Between one `done` pulse and the next accepted `start`, `sig_out`, `exp_out`, `guard` and `sticky` hold their values, whatever the data inputs do.
- R5: Let P be the 106-bit integer product `sig_a * sig_b`. When P bit 105 is 0 (product below 2), `sig_out` is P[104:52] and `exp_out` equals `exp_in`.
- R6: When P bit 105 is 1 (product 2 or more), `sig_out` is P[105:53] and `exp_out` equals `exp_in + 1`.
- R7: `guard` is the bit of P directly below the retained field: P[51] when bit 105 is 0, or P[52] when it is 1.
- R8: `sticky` is the OR of every bit of P below the guard bit. This includes the bits dropped from the accumulator during the steps.
- R9: `exp_in` and `exp_out` are 13-bit two's complement. Negative exponents and an increment from 2046 to 2047 come out exactly.
- R10: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiply when idle |
| sig_a | input | 53 | Multiplier significand, bit 52 set |
| sig_b | input | 53 | Multiplicand significand, bit 52 set |
| exp_in | input | 13 | Signed working exponent |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| sig_out | output | 53 | Normalised product significand |
| exp_out | output | 13 | Adjusted signed exponent |
| guard | output | 1 | First bit below the retained significand |
| sticky | output | 1 | OR of all bits below the guard bit |

## Verification
On every cycle, the assertions check:
- the one-cycle `done` pulse and its fixed distance from the accepted `start`;
- that `busy` is low while `done` is high;
- that the outputs are frozen while idle;
- that the leading significand bit is set at `done`;
- that the exponent moved by zero or one.

The arithmetic itself needs the bench's scenarios, because only a reference product shows whether the retained field, guard and sticky are correct. That covers:
- the exact-power case and the all-ones carry case;
- a guard-only rounding case;
- dense bit patterns.

Whether a second `start` during a run is really ignored can only be seen by comparing a finished result against its own operands.

// File: rtl/rsm_pkg.sv
// Shared types for the radix-16 significand multiplier.
package rsm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } rsm_state_t;
endpackage

// File: rtl/rsm_ctrl.sv
// Sequencer: accepts start when idle, runs ITER nibble steps, then one
// finishing cycle. Assumes ITER >= 1.
module rsm_ctrl
    import rsm_pkg::*;
#(
    parameter int ITER = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic load,
    output logic step,
    output logic finish
);
    localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

    rsm_state_t         state;
    logic [CNT_W-1:0]   cnt;

    assign busy   = (state != ST_IDLE);
    assign load   = start && (state == ST_IDLE);
    assign step   = (state == ST_RUN);
    assign finish = (state == ST_FIN);

    // State and step counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    cnt   <= '0;
                end
                ST_RUN: begin
                    if (cnt == LAST) state <= ST_FIN;
                    cnt <= cnt + 1'b1;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rsm_step.sv
// One radix-16 shift-and-add step: the low nibble of the accumulator is
// folded into sticky, the accumulator moves right by RAD bits, and each
// set bit k of the multiplier nibble adds the multiplicand shifted by k.
// Assumes the widths leave headroom, so no sum overflows ACC_W.
module rsm_step #(
    parameter int ACC_W = 64,
    parameter int RAD   = 4
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] mcand,
    input  logic [RAD-1:0]   nib,
    input  logic             st_in,
    output logic [ACC_W-1:0] acc_nx,
    output logic             st_nx
);
    logic [ACC_W-1:0] part [RAD];

    for (genvar k = 0; k < RAD; k++) begin : g_part
        assign part[k] = nib[k] ? (mcand << k) : '0;
    end

    // Sum the shifted accumulator with the selected partial products.
    always_comb begin
        acc_nx = acc >> RAD;
        for (int k = 0; k < RAD; k++) acc_nx = acc_nx + part[k];
        st_nx = st_in | (|acc[RAD-1:0]);
    end
endmodule

// File: rtl/rsm_norm.sv
// Final alignment: when the leading product bit sits at LEAD the exponent
// is bumped, otherwise the product moves up one place. It then splits off
// the retained field, the guard bit and the remaining sticky bits.
// Assumes normalised inputs, so the leading bit is at LEAD or LEAD-1.
module rsm_norm #(
    parameter int ACC_W = 64,
    parameter int SIG_W = 53,
    parameter int EXP_W = 13,
    parameter int LEAD  = 60
) (
    input  logic [ACC_W-1:0]        acc,
    input  logic                    st_in,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic [SIG_W-1:0]        sig,
    output logic signed [EXP_W-1:0] exp_o,
    output logic                    grd,
    output logic                    stk
);
    localparam int GPOS = LEAD - SIG_W;

    logic             carry;
    logic [ACC_W-1:0] aligned;

    // Align, then split into significand, guard and sticky.
    always_comb begin
        carry   = acc[LEAD];
        aligned = carry ? acc : (acc << 1);
        sig     = aligned[LEAD -: SIG_W];
        grd     = aligned[GPOS];
        stk     = st_in | (|aligned[GPOS-1:0]);
        exp_o   = exp_in + $signed({{(EXP_W-1){1'b0}}, carry});
    end
endmodule

// File: rtl/radix16_sig_mul.sv
// Iterative significand multiplier that retires RAD multiplier bits per
// clock. Result registers are written only on the finishing cycle and hold
// until the next operation. Assumes both significands have their top bit set.
module radix16_sig_mul #(
    parameter int SIG_W = 53,
    parameter int EXP_W = 13,
    parameter int RAD   = 4,
    parameter int GRD   = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [SIG_W-1:0]        sig_a,
    input  logic [SIG_W-1:0]        sig_b,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic                    busy,
    output logic                    done,
    output logic [SIG_W-1:0]        sig_out,
    output logic signed [EXP_W-1:0] exp_out,
    output logic                    guard,
    output logic                    sticky
);
    localparam int ITER  = (SIG_W + RAD - 1) / RAD;
    localparam int ACC_W = SIG_W + GRD + RAD;
    localparam int LEAD  = 2 * SIG_W - 1 + GRD - RAD * (ITER - 1);
    localparam int PAD_W = ACC_W - SIG_W - GRD;

    logic                    load, step, finish;
    logic [ACC_W-1:0]        acc_r, mc_r, acc_nx;
    logic [SIG_W-1:0]        mp_r;
    logic                    st_r, st_nx;
    logic signed [EXP_W-1:0] exp_r;
    logic [SIG_W-1:0]        n_sig;
    logic signed [EXP_W-1:0] n_exp;
    logic                    n_grd, n_stk;

    rsm_ctrl #(.ITER(ITER)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .load(load), .step(step), .finish(finish)
    );

    rsm_step #(.ACC_W(ACC_W), .RAD(RAD)) u_step (
        .acc(acc_r), .mcand(mc_r), .nib(mp_r[RAD-1:0]), .st_in(st_r),
        .acc_nx(acc_nx), .st_nx(st_nx)
    );

    rsm_norm #(.ACC_W(ACC_W), .SIG_W(SIG_W), .EXP_W(EXP_W), .LEAD(LEAD)) u_norm (
        .acc(acc_r), .st_in(st_r), .exp_in(exp_r),
        .sig(n_sig), .exp_o(n_exp), .grd(n_grd), .stk(n_stk)
    );

    // Working registers: load operands, then iterate one nibble per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r <= '0;
            mc_r  <= '0;
            mp_r  <= '0;
            st_r  <= 1'b0;
            exp_r <= '0;
        end else if (load) begin
            acc_r <= '0;
            mc_r  <= {{PAD_W{1'b0}}, sig_b, {GRD{1'b0}}};
            mp_r  <= sig_a;
            st_r  <= 1'b0;
            exp_r <= exp_in;
        end else if (step) begin
            acc_r <= acc_nx;
            st_r  <= st_nx;
            mp_r  <= mp_r >> RAD;
        end
    end

    // Result registers and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_out <= '0;
            exp_out <= '0;
            guard   <= 1'b0;
            sticky  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                sig_out <= n_sig;
                exp_out <= n_exp;
                guard   <= n_grd;
                sticky  <= n_stk;
            end
        end
    end
endmodule

// File: rtl/radix16_sig_mul_chk.sv
// Protocol and range checks for radix16_sig_mul, attached by bind.
module radix16_sig_mul_chk #(
    parameter int SIG_W = 53,
    parameter int EXP_W = 13,
    parameter int LAT   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic [SIG_W-1:0]        sig_out,
    input logic signed [EXP_W-1:0] exp_in,
    input logic signed [EXP_W-1:0] exp_out,
    input logic                    guard,
    input logic                    sticky
);
    logic [7:0]              run_cnt;
    logic signed [EXP_W-1:0] exp_cap;
    logic signed [EXP_W-1:0] exp_diff;

    // Count edges since the accepted start and capture its exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            exp_cap <= '0;
        end else if (start && !busy) begin
            run_cnt <= 8'd1;
            exp_cap <= exp_in;
        end else if (done) begin
            run_cnt <= '0;
        end else if (run_cnt != 0) begin
            run_cnt <= run_cnt + 8'd1;
        end
    end

    assign exp_diff = exp_out - exp_cap;

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == 8'(LAT)));
    assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |=> ($stable(sig_out) && $stable(exp_out)
                              && $stable(guard) && $stable(sticky)));
    assert_leading_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sig_out[SIG_W-1]);
    assert_exp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (exp_diff == 0 || exp_diff == 1));
endmodule

bind radix16_sig_mul radix16_sig_mul_chk #(
    .SIG_W(SIG_W), .EXP_W(EXP_W), .LAT(ITER + 2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .sig_out(sig_out), .exp_in(exp_in), .exp_out(exp_out),
    .guard(guard), .sticky(sticky)
);

// File: tb/radix16_sig_mul_test.sv
module radix16_sig_mul_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    localparam int EXP_LAT = 16;

    localparam logic [52:0] TA [NV] = '{
        53'h10000000000000, 53'h18000000000000, 53'h1FFFFFFFFFFFFF,
        53'h10000000000000, 53'h123456789ABCDE, 53'h18000000000000,
        53'h15555555555555};
    localparam logic [52:0] TB [NV] = '{
        53'h10000000000000, 53'h18000000000000, 53'h1FFFFFFFFFFFFF,
        53'h1FFFFFFFFFFFFF, 53'h1FEDCBA9876543, 53'h10000000000001,
        53'h1AAAAAAAAAAAAB};
    localparam int TE [NV] = '{0, -1, 2046, -1022, 100, 1023, -4000};
    localparam int TX [NV] = '{0, 0, 2047, -1022, 101, 1023, -3999};

    logic clk = 0, rst_n = 0, start = 0;
    logic [52:0] sig_a = '0, sig_b = '0;
    logic signed [12:0] exp_in = '0;
    logic busy, done, guard, sticky;
    logic [52:0] sig_out;
    logic signed [12:0] exp_out;

    int n_tests = 0, n_fail = 0, lat = 0;
    logic [52:0] r_sig;
    logic r_g, r_s, r_c;

    radix16_sig_mul uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sig_a(sig_a), .sig_b(sig_b),
        .exp_in(exp_in), .busy(busy), .done(done), .sig_out(sig_out),
        .exp_out(exp_out), .guard(guard), .sticky(sticky));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Reference product split from the requirements.
    task automatic ref_mul(input logic [52:0] a, input logic [52:0] b);
        logic [105:0] p;
        p = {53'b0, a} * {53'b0, b};
        r_c = p[105];
        if (r_c) begin
            r_sig = p[105:53]; r_g = p[52]; r_s = |p[51:0];
        end else begin
            r_sig = p[104:52]; r_g = p[51]; r_s = |p[50:0];
        end
    endtask

    task automatic issue(input logic [52:0] a, input logic [52:0] b, input int e);
        sig_a = a; sig_b = b; exp_in = 13'(e); start = 1;
        @(negedge clk);
        start = 0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input int x, input int idx);
        ref_mul(TA[idx], TB[idx]);
        chk(sig_out == r_sig, r_c ? "R6 sig" : "R5 sig", 64'(sig_out), 64'(r_sig));
        chk(exp_out == 13'(x), "R9 exp", 64'(exp_out), 64'(13'(x)));
        chk(guard == r_g, "R7 guard", 64'(guard), 64'(r_g));
        chk(sticky == r_s, "R8 sticky", 64'(sticky), 64'(r_s));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [52:0] h_sig;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done, "R1 ctrl", 64'({busy, done}), 64'(0));
        chk(sig_out == 0 && exp_out == 0 && !guard && !sticky, "R1 data",
            64'(sig_out), 64'(0));
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(TA[i], TB[i], TE[i]);
            chk(lat == EXP_LAT, "R2 latency", 64'(lat), 64'(EXP_LAT));
            chk(!busy, "R10 idle at done", 64'(busy), 64'(0));
            check_result(TX[i], i);
            @(negedge clk);
            chk(!done, "R2 pulse width", 64'(done), 64'(0));
        end

        // R4: outputs hold while inputs change without start.
        h_sig = sig_out;
        sig_a = 53'h1ABCDEF0123456; sig_b = 53'h13579BDF2468AC; exp_in = 13'sd7;
        repeat (6) @(negedge clk);
        chk(sig_out == h_sig && exp_out == 13'(TX[NV-1]), "R4 hold",
            64'(sig_out), 64'(h_sig));

        // R3 and R10: start while busy is ignored.
        sig_a = TA[4]; sig_b = TB[4]; exp_in = 13'(TE[4]); start = 1;
        @(negedge clk);
        start = 0;
        chk(busy, "R10 busy after start", 64'(busy), 64'(1));
        repeat (4) @(negedge clk);
        sig_a = TA[0]; sig_b = TB[0]; exp_in = 13'(TE[0]); start = 1;
        @(negedge clk);
        start = 0;
        lat = 6;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == EXP_LAT, "R3 latency", 64'(lat), 64'(EXP_LAT));
        check_result(TX[4], 4);
        @(negedge clk);
        chk(!busy, "R3 no second run", 64'(busy), 64'(0));

        // R1: reset in mid-operation clears outputs.
        issue(TA[2], TB[2], TE[2]);
        sig_a = TA[1]; sig_b = TB[1]; start = 1;
        @(negedge clk);
        start = 0; rst_n = 0;
        @(negedge clk);
        chk(!busy && sig_out == 0 && !sticky, "R1 mid reset",
            64'(sig_out), 64'(0));
        rst_n = 1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule